// File: doc/BRIEF.md
# Indirect-Jump Landing-Pad Checker

This block stands between the execute stage and instruction fetch. It decides whether the target of a register-indirect jump may be used. The same rule applies to the full-width form and to both compressed forms, and returns get no exemption. The first program counter of a fresh invocation also passes through the block, because that value comes from untrusted metadata.

The address space repeats every 4 GiB, so only the low 32 bits of the 64-bit target are examined. The code offset is that aliased value minus the code base 0x0040_0000. The offset is legal only when it is inside the loaded code and marks the start of a basic block. Block starts are held in an external bitmap with one bit per 2-byte slot. The block reads that bitmap through a single combinational read port. Bounds are checked first, and at most one bitmap bit is looked up.

A legal target produces an accept pulse carrying the offset. Any violation produces a fatal-fault pulse with a cause code. After a fault the block refuses all further requests until reset, because a fault can never be resumed.

The request side is a valid/ready stream. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high from reset until the first fault and low afterwards. The target and entry flag only need to be held while `req_valid` waits for `req_ready`. The verdict side has no back-pressure: each verdict is a one-cycle pulse in the cycle after the request is taken. Because the verdict follows one cycle after the request, at most one request is ever outstanding.

Top module: `lp_landing_checker`

## Requirements
- R1: After reset, `ok_pulse` and `fault_pulse` are low and `req_ready` is high.
- R2: Bits 63:32 of `req_target` have no effect on the verdict or on the reported offset.
- R3: A target that is taken and legal yields `ok_pulse` exactly one cycle after the handshake. `ok_offset` then equals `req_target[31:0] - 0x0040_0000`.
- R4: An aliased target below 0x0040_0000 faults with cause 1, and `bm_rd_en` stays low for it.
- R5: An offset equal to or greater than `code_len` faults with cause 2, and `bm_rd_en` stays low for it.
- R6: An odd in-range offset faults with cause 3, and `bm_rd_en` stays low for it.
- R7: Offset 0 inside the code is accepted without a bitmap read (`bm_rd_en` low).
- R8: A nonzero, even, in-range offset drives `bm_rd_en` high with `bm_rd_idx = offset >> 1` in the request cycle. It is accepted when `bm_rd_bit` is 1, and faults with cause 4 when `bm_rd_bit` is 0.
- R9: A request with `req_entry` set goes through the identical check. `res_entry` repeats the flag alongside the verdict.
- R10: Once a fault is pulsed, `req_ready` stays low and no further pulse appears until reset.
- R11: Every handshake yields exactly one of `ok_pulse` and `fault_pulse`, never both. No pulse appears without a handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Check request present |
| req_ready | output | 1 | Block can take a request (low once halted) |
| req_target | input | 64 | Computed indirect-jump or entry target |
| req_entry | input | 1 | Request is an invocation entry point |
| code_len | input | 32 | Loaded code length in bytes |
| bm_rd_en | output | 1 | Bitmap lookup strobe |
| bm_rd_idx | output | 31 | Bitmap index (offset divided by 2) |
| bm_rd_bit | input | 1 | Bitmap bit for `bm_rd_idx`, same cycle |
| ok_pulse | output | 1 | Target accepted |
| ok_offset | output | 32 | Code offset of the accepted target |
| fault_pulse | output | 1 | Fatal landing-pad violation |
| fault_cause | output | 3 | 1 below base, 2 beyond length, 3 odd, 4 not a block start |
| res_entry | output | 1 | Entry flag of the request this verdict belongs to |

## Verification
The hardest part to reach from the ports is the halted state, and what happens to requests after it. A fault is terminal, so each fault case costs a reset. The bench therefore runs every accepting pattern first, then resets before each individual fault. After one fault it keeps offering a legal target and checks that `req_ready` stays low and no verdict appears. The bitmap model marks every fourth slot as a block start. As a result, even in-range offsets next to legal ones land mid-block, which exercises the cause-4 path.

// File: rtl/lp_pkg.sv
package lp_pkg;
  typedef enum logic [2:0] {
    LP_CAUSE_NONE   = 3'd0,
    LP_CAUSE_BELOW  = 3'd1,
    LP_CAUSE_BEYOND = 3'd2,
    LP_CAUSE_ODD    = 3'd3,
    LP_CAUSE_NOPAD  = 3'd4
  } lp_cause_e;

  typedef struct packed {
    logic below;
    logic beyond;
    logic odd;
    logic zero;
  } lp_class_t;
endpackage

// File: rtl/lp_offset_calc.sv
module lp_offset_calc
  import lp_pkg::*;
#(
  parameter int TGT_W = 64,
  parameter int ALIAS_W = 32,
  parameter logic [ALIAS_W-1:0] CODE_BASE = 32'h0040_0000
) (
  input  logic [TGT_W-1:0]   target,
  input  logic [ALIAS_W-1:0] code_len,
  output logic [ALIAS_W-1:0] offset,
  output lp_class_t          cls
);
  logic [ALIAS_W-1:0] aliased;

  always_comb begin
    aliased    = target[ALIAS_W-1:0];
    offset     = aliased - CODE_BASE;
    cls.below  = (aliased < CODE_BASE);
    cls.beyond = !cls.below && (offset >= code_len);
    cls.odd    = offset[0];
    cls.zero   = (offset == '0);
  end
endmodule

// File: rtl/lp_pad_probe.sv
module lp_pad_probe
  import lp_pkg::*;
#(
  parameter int ALIAS_W = 32,
  localparam int IDX_W = ALIAS_W - 1
) (
  input  logic               valid,
  input  logic [ALIAS_W-1:0] offset,
  input  lp_class_t          cls,
  output logic               rd_en,
  output logic [IDX_W-1:0]   rd_idx,
  input  logic               rd_bit,
  output logic               pass,
  output lp_cause_e          cause
);
  always_comb begin
    rd_idx = offset[ALIAS_W-1:1];
    rd_en  = 1'b0;
    pass   = 1'b0;
    cause  = LP_CAUSE_NONE;
    if (cls.below) begin
      cause = LP_CAUSE_BELOW;
    end else if (cls.beyond) begin
      cause = LP_CAUSE_BEYOND;
    end else if (cls.odd) begin
      cause = LP_CAUSE_ODD;
    end else if (cls.zero) begin
      pass = 1'b1;
    end else begin
      rd_en = valid;
      if (rd_bit) pass  = 1'b1;
      else        cause = LP_CAUSE_NOPAD;
    end
  end
endmodule

// File: rtl/lp_verdict_reg.sv
module lp_verdict_reg
  import lp_pkg::*;
#(
  parameter int ALIAS_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic               pass,
  input  lp_cause_e          cause,
  input  logic [ALIAS_W-1:0] offset,
  input  logic               entry,
  output logic               ready,
  output logic               ok_q,
  output logic               fault_q,
  output logic [ALIAS_W-1:0] offset_q,
  output lp_cause_e          cause_q,
  output logic               entry_q
);
  logic halted_q;

  assign ready = !halted_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halted_q <= 1'b0;
      ok_q     <= 1'b0;
      fault_q  <= 1'b0;
      offset_q <= '0;
      cause_q  <= LP_CAUSE_NONE;
      entry_q  <= 1'b0;
    end else begin
      ok_q    <= take && pass;
      fault_q <= take && !pass;
      if (take) begin
        offset_q <= offset;
        cause_q  <= pass ? LP_CAUSE_NONE : cause;
        entry_q  <= entry;
        if (!pass) halted_q <= 1'b1;
      end
    end
  end

  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok_q && fault_q)); // R11
  AST_PULSE_NEEDS_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_q || fault_q) |-> $past(take)); // R11
  AST_HALT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    halted_q |=> halted_q); // R10
  AST_SILENT_WHEN_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_q && !fault_q) |-> !ok_q); // R10
  AST_FAULT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |-> (cause_q != LP_CAUSE_NONE)); // R4
endmodule

// File: rtl/lp_landing_checker.sv
module lp_landing_checker
  import lp_pkg::*;
#(
  parameter int TGT_W = 64,
  parameter int ALIAS_W = 32,
  parameter logic [ALIAS_W-1:0] CODE_BASE = 32'h0040_0000,
  localparam int IDX_W = ALIAS_W - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [TGT_W-1:0]   req_target,
  input  logic               req_entry,
  input  logic [ALIAS_W-1:0] code_len,
  output logic               bm_rd_en,
  output logic [IDX_W-1:0]   bm_rd_idx,
  input  logic               bm_rd_bit,
  output logic               ok_pulse,
  output logic [ALIAS_W-1:0] ok_offset,
  output logic               fault_pulse,
  output logic [2:0]         fault_cause,
  output logic               res_entry
);
  logic [ALIAS_W-1:0] offset;
  lp_class_t          cls;
  logic               pass;
  lp_cause_e          cause;
  lp_cause_e          cause_q;
  logic               take;
  logic               probe_valid;

  lp_offset_calc #(.TGT_W(TGT_W), .ALIAS_W(ALIAS_W), .CODE_BASE(CODE_BASE)) u_calc (
    .target(req_target), .code_len(code_len), .offset(offset), .cls(cls));

  assign probe_valid = req_valid && req_ready;

  lp_pad_probe #(.ALIAS_W(ALIAS_W)) u_probe (
    .valid(probe_valid), .offset(offset), .cls(cls),
    .rd_en(bm_rd_en), .rd_idx(bm_rd_idx), .rd_bit(bm_rd_bit),
    .pass(pass), .cause(cause));

  assign take = req_valid && req_ready;

  lp_verdict_reg #(.ALIAS_W(ALIAS_W)) u_verdict (
    .clk(clk), .rst_n(rst_n), .take(take), .pass(pass), .cause(cause),
    .offset(offset), .entry(req_entry), .ready(req_ready),
    .ok_q(ok_pulse), .fault_q(fault_pulse), .offset_q(ok_offset),
    .cause_q(cause_q), .entry_q(res_entry));

  assign fault_cause = cause_q;

  AST_NO_READ_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    bm_rd_en |-> !cls.below); // R4
  AST_NO_READ_BEYOND: assert property (@(posedge clk) disable iff (!rst_n)
    bm_rd_en |-> !cls.beyond); // R5
  AST_NO_READ_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    bm_rd_en |-> !cls.odd); // R6
  AST_NO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bm_rd_en |-> !cls.zero); // R7
  AST_MISS_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_rd_en && !bm_rd_bit) |=> (fault_pulse && fault_cause == 3'd4)); // R8
  AST_FAULT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |-> !req_ready); // R10
endmodule

// File: tb/lp_landing_checker_tb.sv
module lp_landing_checker_tb;
  localparam logic [31:0] BASE = 32'h0040_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_target = '0;
  logic        req_entry = 1'b0;
  logic [31:0] code_len = 32'h1000;
  logic        bm_rd_en;
  logic [30:0] bm_rd_idx;
  logic        bm_rd_bit;
  logic        ok_pulse;
  logic [31:0] ok_offset;
  logic        fault_pulse;
  logic [2:0]  fault_cause;
  logic        res_entry;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit exp_halt = 1'b0;

  typedef struct {
    int          due;
    bit          ok;
    logic [31:0] off;
    logic [2:0]  cause;
    bit          entry;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // bitmap model: every fourth 2-byte slot is a block start
  assign bm_rd_bit = (bm_rd_idx[1:0] == 2'b00);

  lp_landing_checker u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_target(req_target), .req_entry(req_entry), .code_len(code_len),
    .bm_rd_en(bm_rd_en), .bm_rd_idx(bm_rd_idx), .bm_rd_bit(bm_rd_bit),
    .ok_pulse(ok_pulse), .ok_offset(ok_offset), .fault_pulse(fault_pulse),
    .fault_cause(fault_cause), .res_entry(res_entry));

  task automatic fail(input string msg);
    errors++;
    $display("FAIL %s", msg);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    exp_halt = 1'b0;
  endtask

  task automatic send(input logic [63:0] t, input bit ent, input string tag);
    logic [31:0] lo, off;
    bit ok, rd;
    logic [2:0] cause;
    @(negedge clk);
    req_target = t;
    req_entry = ent;
    req_valid = 1'b1;
    #1;
    lo = t[31:0];
    off = lo - BASE;
    ok = 0; rd = 0; cause = 3'd0;
    if (lo < BASE) cause = 3'd1;
    else if (off >= code_len) cause = 3'd2;
    else if (off[0]) cause = 3'd3;
    else if (off == 0) ok = 1;
    else begin
      rd = 1;
      if (off[2:1] == 2'b00) ok = 1; else cause = 3'd4;
    end
    checks++;
    if (req_ready !== !exp_halt)
      fail($sformatf("R10 %s ready act=%b exp=%b", tag, req_ready, !exp_halt));
    if (!exp_halt) begin
      checks++;
      if (bm_rd_en !== rd)
        fail($sformatf("R8 %s bm_rd_en act=%b exp=%b", tag, bm_rd_en, rd));
      else if (rd && bm_rd_idx !== off[31:1])
        fail($sformatf("R8 %s bm_rd_idx act=%h exp=%h", tag, bm_rd_idx, off[31:1]));
      q.push_back('{cyc + 1, ok, off, cause, ent, tag});
      if (!ok) exp_halt = 1'b1;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor / scoreboard (R11)
  always @(negedge clk) begin
    if (rst_n) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (ok_pulse !== e.ok || fault_pulse !== !e.ok)
          fail($sformatf("R11 %s ok/fault act=%b/%b exp=%b/%b", e.tag,
                         ok_pulse, fault_pulse, e.ok, !e.ok));
        else if (e.ok && ok_offset !== e.off)
          fail($sformatf("R3 %s offset act=%h exp=%h", e.tag, ok_offset, e.off));
        else if (!e.ok && fault_cause !== e.cause)
          fail($sformatf("R4 %s cause act=%0d exp=%0d", e.tag, fault_cause, e.cause));
        else if (res_entry !== e.entry)
          fail($sformatf("R9 %s entry act=%b exp=%b", e.tag, res_entry, e.entry));
      end else if (ok_pulse || fault_pulse) begin
        checks++;
        fail($sformatf("R11 unexpected pulse ok=%b fault=%b exp=0/0", ok_pulse, fault_pulse));
      end
    end
  end

  task automatic finish_run();
    repeat (4) @(negedge clk);
    checks++;
    if (q.size() != 0) fail($sformatf("R11 missing verdicts act=%0d exp=0", q.size()));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 50000);
    checks++;
    fail("watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    checks++;
    if (ok_pulse !== 1'b0 || fault_pulse !== 1'b0 || req_ready !== 1'b1)
      fail($sformatf("R1 reset ok=%b fault=%b ready=%b exp=0/0/1",
                     ok_pulse, fault_pulse, req_ready));
    send(64'h0000_0000_0040_0010, 0, "R3 legal start");
    send(64'hFFFF_0000_0040_0020, 0, "R2 upper bits");
    send(64'h0000_0000_0040_0000, 0, "R7 offset zero");
    send(64'h0000_0001_0040_0008, 1, "R9 entry legal");
    send(64'h0000_0000_0040_0FF8, 0, "R5 last even slot");
    send(64'h0000_0000_0040_0004, 0, "R8 mid-block");
    send(64'h0000_0000_0040_0010, 0, "R10 after fault");
    send(64'h0000_0000_0040_0000, 0, "R10 zero after fault");
    do_reset();
    send(64'h0000_0000_003F_FFFE, 0, "R4 below base");
    do_reset();
    send(64'h0000_0000_0040_1000, 0, "R5 at length");
    do_reset();
    send(64'h0000_0000_0040_0011, 0, "R6 odd offset");
    do_reset();
    send(64'h0000_0000_0040_000C, 1, "R9 entry bad");
    do_reset();
    code_len = 32'h0;
    send(64'h0000_0000_0040_0000, 0, "R7 zero empty code");
    code_len = 32'h1000;
    finish_run();
  end
endmodule